// File: doc/BRIEF.md
# Streaming Counting Sort Engine

The engine sorts frames of small unsigned integers without comparing any two elements. Every accepted element increments the counter for its value, which lives in an inferred dual-port RAM with one counter per possible value. When the input frame closes, a reader walks the counters from the lowest value to the highest and emits each value as many times as it was counted. The result is an ascending stream that uses the same three signals as the input: a frame flag, a valid strobe and 6-bit data. While the stream is produced, the reader also derives the minimum, the median, the maximum, the mean and the most frequent value of the frame.

There are two counter banks. The counting side fills one bank while the reader drains the other. The roles swap on every falling edge of the input frame flag, so a new frame can arrive while the previous one is still being emitted. Counter updates run through a three-stage read-modify-write pipeline: read address, then read data, then write. Equal values that arrive one or two cycles apart take their base count from the results still in flight, not from the RAM. The reader writes zero to each counter right after reading it, so a drained bank is clean for its next frame.

The reader is a state machine:
- RD_IDLE waits for the input frame to close and moves to RD_SETTLE on that edge.
- RD_SETTLE lasts two cycles, while the last updates land, and then moves to RD_PRIME.
- RD_PRIME issues the read of counter 0 and moves to RD_SCAN.
- RD_SCAN handles one counter per cycle. It clears the counter. A count of 0 or 1 moves straight on to the next counter, emitting one element for a count of 1. A larger count emits one element and moves to RD_HOLD.
- RD_HOLD repeats the same value while the remaining count drops. When the last copy goes out it returns to RD_SCAN, or to RD_CLOSE after the top value.
- RD_CLOSE publishes the statistics and moves to RD_IDLE.

Top module: `tally_sort_engine`

## Requirements
- R1: Each output frame carries exactly the elements accepted in the matching input frame, in non-decreasing order, on out_data while out_valid is high, with each value repeated once for every time it was accepted.
- R2: An element is accepted only in a cycle where in_frame and in_valid are both high; in_valid while in_frame is low has no effect on any result.
- R3: Equal values in consecutive cycles, or two cycles apart, are each counted exactly once.
- R4: out_frame rises in the cycle after the clock edge that first samples in_frame low, stays high through the last out_valid of that frame and falls in the following cycle; out_valid is never high while out_frame is low.
- R5: Values that did not occur produce no output element; the extreme values 0 and 63 are emitted like any other.
- R6: A new input frame may start right after the previous one closes and is counted in the other bank while the previous frame is emitted, provided it closes only after the previous readout has ended.
- R7: A readout leaves its bank cleared, so no element of an earlier frame appears in a later frame's output.
- R8: stat_min is the first output element, stat_median the element at position 32 (counting from 0), and stat_max the last output element of the frame.
- R9: stat_mean is the sum of the frame's 64 elements shifted right by 6 bits (floor of the average).
- R10: stat_mode is the value with the highest count; among equal highest counts the smaller value wins.
- R11: stat_valid is a one-cycle pulse in the first cycle out_frame is low after a readout, and the statistics hold their values until the next pulse.
- R12: While reset is asserted and right after it, out_frame, out_valid and stat_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_frame | input | 1 | Input frame flag; its falling edge closes the frame |
| in_valid | input | 1 | Input element strobe |
| in_data | input | 6 | Input element value |
| out_frame | output | 1 | Output frame flag |
| out_valid | output | 1 | Output element strobe |
| out_data | output | 6 | Output element value, ascending |
| stat_valid | output | 1 | One-cycle pulse: statistics updated |
| stat_min | output | 6 | Smallest element of the last frame |
| stat_median | output | 6 | Element at sorted position 32 |
| stat_max | output | 6 | Largest element of the last frame |
| stat_mean | output | 6 | Sum of the elements shifted right by 6 |
| stat_mode | output | 6 | Most frequent value, smaller value on ties |

## Verification
A missed forward in the update pipeline leaves a counter one short. The output frame then has one copy too few of that value, which the scoreboard sees as a mismatch at that position and as a wrong element count once stat_valid arrives. A counter that the reader fails to clear shows up one bank cycle later, two frames on, as extra copies in that frame's output. A wrong transition in the reader shows up as a lost element, a repeated element or an out-of-order element within the same readout, or as out_frame going high in the wrong cycle, which the bench checks on the cycle right after every frame close.

// File: rtl/tally_pkg.sv
package tally_pkg;

    typedef enum logic [2:0] {
        RD_IDLE,
        RD_SETTLE,
        RD_PRIME,
        RD_SCAN,
        RD_HOLD,
        RD_CLOSE
    } rd_state_t;

endpackage

// File: rtl/tally_ram.sv
module tally_ram #(
    parameter int ADDR_W = 6,
    parameter int WORD_W = 7
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] wa,
    input  logic [WORD_W-1:0] wd,
    input  logic [ADDR_W-1:0] ra,
    output logic [WORD_W-1:0] q
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] mem [DEPTH];

    // Power-up contents are zero; afterwards the reader keeps drained banks zero.
    initial begin
        for (int i = 0; i < DEPTH; i++) mem[i] = '0;
    end

    always_ff @(posedge clk) begin
        if (we) mem[wa] <= wd;
        q <= mem[ra];
    end
endmodule

// File: rtl/tally_updater.sv
module tally_updater #(
    parameter int DATA_W = 6,
    parameter int CNT_W  = 7
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_frame,
    input  logic                          in_valid,
    input  logic [DATA_W-1:0]             in_data,
    input  logic                          fill_bank,
    input  logic [1:0][CNT_W-1:0]         bank_q,
    output logic [DATA_W-1:0]             rd_addr,
    output logic                          we,
    output logic [DATA_W-1:0]             wa,
    output logic [CNT_W-1:0]              wd,
    output logic                          wbank
);
    // Stage 1: read address, stage 2: read data, stage 3: write port.
    // Stage 4 remembers the write that lands on the same edge as stage 2's read.
    logic              v1, v2, v3, v4;
    logic [DATA_W-1:0] a1, a2, a3, a4;
    logic              b1, b2, b3, b4;
    logic [CNT_W-1:0]  c3, c4;

    logic              hit3, hit4;
    logic [CNT_W-1:0]  base, bumped;

    always_comb begin
        hit3   = v3 && (a3 == a2) && (b3 == b2);
        hit4   = v4 && (a4 == a2) && (b4 == b2);
        base   = hit3 ? c3 : (hit4 ? c4 : bank_q[b2]);
        bumped = base + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v1 <= 1'b0; v2 <= 1'b0; v3 <= 1'b0; v4 <= 1'b0;
            a1 <= '0; a2 <= '0; a3 <= '0; a4 <= '0;
            b1 <= 1'b0; b2 <= 1'b0; b3 <= 1'b0; b4 <= 1'b0;
            c3 <= '0; c4 <= '0;
        end else begin
            v1 <= in_frame && in_valid;
            a1 <= in_data;
            b1 <= fill_bank;
            v2 <= v1; a2 <= a1; b2 <= b1;
            v3 <= v2; a3 <= a2; b3 <= b2; c3 <= bumped;
            v4 <= v3; a4 <= a3; b4 <= b3; c4 <= c3;
        end
    end

    assign rd_addr = a1;
    assign we      = v3;
    assign wa      = a3;
    assign wd      = c3;
    assign wbank   = b3;

    // R3: an element following an equal one in flight writes one more than it.
    assert_fwd_increment_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (v2 && v3 && (a2 == a3) && (b2 == b3)) |=> (wd == $past(wd) + CNT_W'(1)));
endmodule

// File: rtl/tally_reader.sv
module tally_reader
    import tally_pkg::*;
#(
    parameter int DATA_W    = 6,
    parameter int CNT_W     = 7,
    parameter int FRAME_LEN = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_end,
    input  logic [CNT_W-1:0]  q,
    output logic [DATA_W-1:0] rd_addr,
    output logic              clr_we,
    output logic [DATA_W-1:0] clr_addr,
    output logic              out_frame,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              stat_valid,
    output logic [DATA_W-1:0] stat_min,
    output logic [DATA_W-1:0] stat_median,
    output logic [DATA_W-1:0] stat_max,
    output logic [DATA_W-1:0] stat_mean,
    output logic [DATA_W-1:0] stat_mode
);
    localparam int IDX_W  = $clog2(FRAME_LEN + 1);
    localparam int SHIFT  = $clog2(FRAME_LEN);
    localparam int SUM_W  = DATA_W + SHIFT + 1;
    localparam logic [DATA_W-1:0] TOP_V = {DATA_W{1'b1}};
    localparam logic [IDX_W-1:0]  MID_I = IDX_W'(FRAME_LEN / 2);

    rd_state_t state, nxt;

    logic              settle_q;
    logic [DATA_W-1:0] ptr;
    logic [CNT_W-1:0]  rem;
    logic [IDX_W-1:0]  idx;
    logic [SUM_W-1:0]  sum_acc;
    logic [CNT_W-1:0]  best_cnt;
    logic [DATA_W-1:0] min_acc, med_acc, max_acc, mode_acc;
    logic              emit, advance;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RD_IDLE;
        else        state <= nxt;
    end

    // Next state and per-cycle control.
    always_comb begin
        nxt     = state;
        emit    = 1'b0;
        advance = 1'b0;
        clr_we  = 1'b0;
        rd_addr = ptr;
        unique case (state)
            RD_IDLE: begin
                if (frame_end) nxt = RD_SETTLE;
            end
            RD_SETTLE: begin
                if (settle_q) nxt = RD_PRIME;
            end
            RD_PRIME: begin
                rd_addr = '0;
                nxt     = RD_SCAN;
            end
            RD_SCAN: begin
                clr_we = 1'b1;
                emit   = (q != '0);
                if (q > CNT_W'(1)) begin
                    nxt = RD_HOLD;
                end else if (ptr == TOP_V) begin
                    nxt = RD_CLOSE;
                end else begin
                    advance = 1'b1;
                    rd_addr = ptr + DATA_W'(1);
                end
            end
            RD_HOLD: begin
                emit = 1'b1;
                if (rem == CNT_W'(1)) begin
                    if (ptr == TOP_V) begin
                        nxt = RD_CLOSE;
                    end else begin
                        advance = 1'b1;
                        rd_addr = ptr + DATA_W'(1);
                        nxt     = RD_SCAN;
                    end
                end
            end
            RD_CLOSE: begin
                nxt = RD_IDLE;
            end
            default: nxt = RD_IDLE;
        endcase
    end

    assign clr_addr = ptr;

    // Outputs and datapath registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            settle_q    <= 1'b0;
            ptr         <= '0;
            rem         <= '0;
            idx         <= '0;
            sum_acc     <= '0;
            best_cnt    <= '0;
            min_acc     <= '0;
            med_acc     <= '0;
            max_acc     <= '0;
            mode_acc    <= '0;
            out_frame   <= 1'b0;
            out_valid   <= 1'b0;
            out_data    <= '0;
            stat_valid  <= 1'b0;
            stat_min    <= '0;
            stat_median <= '0;
            stat_max    <= '0;
            stat_mean   <= '0;
            stat_mode   <= '0;
        end else begin
            settle_q   <= (state == RD_SETTLE) ? ~settle_q : 1'b0;
            out_frame  <= (nxt != RD_IDLE);
            out_valid  <= emit;
            stat_valid <= (state == RD_CLOSE);
            if (emit) out_data <= ptr;

            if (state == RD_PRIME) begin
                ptr      <= '0;
                idx      <= '0;
                sum_acc  <= '0;
                best_cnt <= '0;
                mode_acc <= '0;
            end

            if (advance) ptr <= ptr + DATA_W'(1);

            if (state == RD_SCAN) begin
                if (q > CNT_W'(1)) rem <= q - CNT_W'(1);
                if (q > best_cnt) begin
                    best_cnt <= q;
                    mode_acc <= ptr;
                end
            end else if (state == RD_HOLD) begin
                rem <= rem - CNT_W'(1);
            end

            if (emit) begin
                idx     <= idx + IDX_W'(1);
                sum_acc <= sum_acc + SUM_W'(ptr);
                max_acc <= ptr;
                if (idx == '0)   min_acc <= ptr;
                if (idx == MID_I) med_acc <= ptr;
            end

            if (state == RD_CLOSE) begin
                stat_min    <= min_acc;
                stat_median <= med_acc;
                stat_max    <= max_acc;
                stat_mean   <= DATA_W'(sum_acc >> SHIFT);
                stat_mode   <= mode_acc;
            end
        end
    end

    // R4: elements only inside the output frame.
    assert_valid_in_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_frame);

    // R4: the output frame opens one cycle after the input frame closes.
    assert_frame_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RD_IDLE && frame_end) |=> out_frame);

    // R1: consecutive elements never descend.
    assert_ascending_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(out_valid)) |-> (out_data >= $past(out_data)));

    // R8: published order statistics are ordered.
    assert_stat_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stat_valid |-> (stat_min <= stat_median && stat_median <= stat_max
                        && stat_min <= stat_mean && stat_mean <= stat_max));

    // R11: the pulse follows the close of the output frame.
    assert_stat_after_frame_R11: assert property (@(posedge clk) disable iff (!rst_n)
        stat_valid |-> (!out_frame && $past(out_frame)));

    // R6: a frame may close only once the previous readout has ended.
    assert_frame_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |-> (state == RD_IDLE));
endmodule

// File: rtl/tally_sort_engine.sv
module tally_sort_engine #(
    parameter int DATA_W    = 6,
    parameter int FRAME_LEN = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_frame,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_frame,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              stat_valid,
    output logic [DATA_W-1:0] stat_min,
    output logic [DATA_W-1:0] stat_median,
    output logic [DATA_W-1:0] stat_max,
    output logic [DATA_W-1:0] stat_mean,
    output logic [DATA_W-1:0] stat_mode
);
    localparam int CNT_W     = $clog2(FRAME_LEN + 1);
    localparam int NUM_BANKS = 2;

    logic in_frame_q, fill_bank, drain_bank, frame_end;

    logic [DATA_W-1:0] upd_ra, upd_wa, rdr_ra, rdr_wa;
    logic [CNT_W-1:0]  upd_wd;
    logic              upd_we, upd_wbank, rdr_we;

    logic [NUM_BANKS-1:0]             bank_we;
    logic [NUM_BANKS-1:0][DATA_W-1:0] bank_wa, bank_ra;
    logic [NUM_BANKS-1:0][CNT_W-1:0]  bank_wd, bank_q;
    logic [CNT_W-1:0]                 rdr_q;

    assign frame_end = in_frame_q && !in_frame;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_frame_q <= 1'b0;
            fill_bank  <= 1'b0;
            drain_bank <= 1'b1;
        end else begin
            in_frame_q <= in_frame;
            if (frame_end) begin
                fill_bank  <= ~fill_bank;
                drain_bank <= fill_bank;
            end
        end
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic upd_owns;
        assign upd_owns   = upd_we && (upd_wbank == 1'(b));
        assign bank_we[b] = upd_owns || (rdr_we && (drain_bank == 1'(b)));
        assign bank_wa[b] = upd_owns ? upd_wa : rdr_wa;
        assign bank_wd[b] = upd_owns ? upd_wd : '0;
        assign bank_ra[b] = (drain_bank == 1'(b)) ? rdr_ra : upd_ra;

        tally_ram #(.ADDR_W(DATA_W), .WORD_W(CNT_W)) i_ram (
            .clk (clk),
            .we  (bank_we[b]),
            .wa  (bank_wa[b]),
            .wd  (bank_wd[b]),
            .ra  (bank_ra[b]),
            .q   (bank_q[b])
        );
    end

    assign rdr_q = bank_q[drain_bank];

    tally_updater #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_updater (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_frame  (in_frame),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .fill_bank (fill_bank),
        .bank_q    (bank_q),
        .rd_addr   (upd_ra),
        .we        (upd_we),
        .wa        (upd_wa),
        .wd        (upd_wd),
        .wbank     (upd_wbank)
    );

    tally_reader #(.DATA_W(DATA_W), .CNT_W(CNT_W), .FRAME_LEN(FRAME_LEN)) i_reader (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_end   (frame_end),
        .q           (rdr_q),
        .rd_addr     (rdr_ra),
        .clr_we      (rdr_we),
        .clr_addr    (rdr_wa),
        .out_frame   (out_frame),
        .out_valid   (out_valid),
        .out_data    (out_data),
        .stat_valid  (stat_valid),
        .stat_min    (stat_min),
        .stat_median (stat_median),
        .stat_max    (stat_max),
        .stat_mean   (stat_mean),
        .stat_mode   (stat_mode)
    );

    // R6: counting and clearing never write the same bank in one cycle.
    assert_bank_apart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_we && rdr_we) |-> (upd_wbank != drain_bank));
endmodule

// File: tb/test_tally_sort_engine.sv
`timescale 1ns/1ps
module test_tally_sort_engine;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       in_frame, in_valid;
    logic [5:0] in_data;
    logic       out_frame, out_valid, stat_valid;
    logic [5:0] out_data, stat_min, stat_median, stat_max, stat_mean, stat_mode;

    int errors = 0;
    int checks = 0;

    logic [5:0] pat [64];
    logic [5:0] exp_val [$];
    string      exp_tag [$];
    logic [5:0] e_min [$], e_med [$], e_max [$], e_mean [$], e_mode [$];
    logic       stat_prev = 1'b0;

    always #2 clk = ~clk;

    tally_sort_engine i_tally_sort_engine (
        .clk (clk), .rst_n (rst_n),
        .in_frame (in_frame), .in_valid (in_valid), .in_data (in_data),
        .out_frame (out_frame), .out_valid (out_valid), .out_data (out_data),
        .stat_valid (stat_valid), .stat_min (stat_min), .stat_median (stat_median),
        .stat_max (stat_max), .stat_mean (stat_mean), .stat_mode (stat_mode)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Driver: sends pat[] as one frame, element every `spacing` cycles, then
    // pushes the expected sorted stream and statistics to the scoreboard.
    task automatic send_frame(input int spacing, input string tag);
        int cnt [64];
        logic [5:0] srt [$];
        int sum, best;
        logic [5:0] mode;
        @(negedge clk);
        in_frame = 1'b0; in_valid = 1'b1; in_data = 6'd13;   // R2: ignored
        @(negedge clk);
        in_valid = 1'b0; in_frame = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 64; i++) begin
            in_valid = 1'b1; in_data = pat[i];
            @(negedge clk);
            for (int k = 1; k < spacing; k++) begin
                in_valid = 1'b0;
                @(negedge clk);
            end
        end
        in_frame = 1'b0; in_valid = 1'b1; in_data = 6'd2;    // R2: ignored
        check(out_frame == 1'b0, "R4 frame low before close", out_frame, 0);
        for (int v = 0; v < 64; v++) cnt[v] = 0;
        for (int i = 0; i < 64; i++) cnt[pat[i]]++;
        sum = 0; best = 0; mode = '0;
        for (int v = 0; v < 64; v++) begin
            for (int r = 0; r < cnt[v]; r++) begin
                srt.push_back(6'(v));
                exp_val.push_back(6'(v));
                exp_tag.push_back(tag);
                sum += v;
            end
            if (cnt[v] > best) begin best = cnt[v]; mode = 6'(v); end
        end
        e_min.push_back(srt[0]);
        e_med.push_back(srt[32]);
        e_max.push_back(srt[63]);
        e_mean.push_back(6'(sum >> 6));
        e_mode.push_back(mode);
        @(negedge clk);
        in_valid = 1'b0;
        check(out_frame == 1'b1, "R4 one-cycle frame latency", out_frame, 1);
    endtask

    // Monitor: pops and compares as results appear.
    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            if (out_valid) begin
                if (exp_val.size() == 0) begin
                    check(1'b0, "R1 unexpected element", out_data, -1);
                end else begin
                    logic [5:0] ev;
                    string      et;
                    ev = exp_val.pop_front();
                    et = exp_tag.pop_front();
                    check(out_data == ev, {"R1 element ", et}, out_data, ev);
                end
            end
            if (stat_prev) check(stat_valid == 1'b0, "R11 pulse width", stat_valid, 0);
            if (stat_valid) begin
                check(out_frame == 1'b0, "R11 pulse after frame", out_frame, 0);
                check(exp_val.size() == 0, "R1 element count", exp_val.size(), 0);
                if (e_min.size() == 0) begin
                    check(1'b0, "R11 unexpected stats", 1, 0);
                end else begin
                    logic [5:0] a, b, c, d, e;
                    a = e_min.pop_front(); b = e_med.pop_front(); c = e_max.pop_front();
                    d = e_mean.pop_front(); e = e_mode.pop_front();
                    check(stat_min == a, "R8 min", stat_min, a);
                    check(stat_median == b, "R8 median", stat_median, b);
                    check(stat_max == c, "R8 max", stat_max, c);
                    check(stat_mean == d, "R9 mean", stat_mean, d);
                    check(stat_mode == e, "R10 mode", stat_mode, e);
                end
            end
            stat_prev = stat_valid;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        summary();
    end

    initial begin
        rst_n = 1'b0; in_frame = 1'b0; in_valid = 1'b0; in_data = '0;
        repeat (3) @(negedge clk);
        check(out_frame == 1'b0 && out_valid == 1'b0 && stat_valid == 1'b0,
              "R12 reset outputs", {out_frame, out_valid, stat_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_frame == 1'b0 && stat_valid == 1'b0, "R12 after reset",
              {out_frame, stat_valid}, 0);

        for (int i = 0; i < 64; i++) pat[i] = 6'(i);          // R5 all values incl. 0, 63
        send_frame(1, "R5 ascending");
        repeat (160) @(negedge clk);
        for (int i = 0; i < 64; i++) pat[i] = 6'(63 - i);
        send_frame(1, "R1 descending");
        repeat (160) @(negedge clk);
        for (int i = 0; i < 64; i++) pat[i] = 6'd17;          // back-to-back equal
        send_frame(1, "R3 constant");
        repeat (160) @(negedge clk);
        for (int i = 0; i < 64; i++) pat[i] = 6'd63;
        send_frame(1, "R5 all 63");
        repeat (160) @(negedge clk);
        for (int i = 0; i < 64; i++) pat[i] = 6'd0;           // must show no 63s
        send_frame(1, "R7 all 0 after 63");
        repeat (160) @(negedge clk);
        for (int i = 0; i < 64; i++) pat[i] = (i % 2 == 1) ? 6'd40 : 6'd3;
        send_frame(1, "R3 R10 alternating tie");
        repeat (160) @(negedge clk);
        for (int i = 0; i < 64; i++) pat[i] = (i % 3 == 2) ? 6'd9 : 6'd50;
        send_frame(1, "R3 pairs");
        repeat (160) @(negedge clk);
        for (int i = 0; i < 64; i++) pat[i] = 6'((i * i * 7 + 3) & 63);
        send_frame(2, "R1 scattered");
        for (int i = 0; i < 64; i++) pat[i] = 6'((i * 5 + 60) & 63);
        send_frame(3, "R6 overlapped");                      // starts during readout
        for (int i = 0; i < 64; i++) pat[i] = 6'((i >> 2) ^ 6'd21);
        send_frame(3, "R6 R7 overlapped again");
        repeat (200) @(negedge clk);
        check(exp_val.size() == 0 && e_min.size() == 0, "R1 all results drained",
              exp_val.size(), 0);
        summary();
    end
endmodule